// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control state machine that sits beside one thread's rename stage in an out-of-order core. Each cycle it decides whether rename may move instructions forward, and how many. It looks at the free entries left in three back-end structures: the reorder buffer, the issue queue and the load/store queue. It also sees stall requests from the execute and retire stages, a reorder-buffer-empty flag, a squash request, serializing-instruction markers, the skid-buffer occupancy and the number of valid instructions on offer.

Instructions that have left rename but are not yet counted by the back-end are subtracted from every free figure before any comparison. The allowed count is clipped to the stage width and to the tightest of the three structures. When a structure cannot take the whole group on offer, the block reports which one, blocks, and tells the previous stage. Leftover instructions then collect in the skid buffer, and that buffer must drain before normal running resumes.

A barrier instruction holds rename until the reorder buffer is empty and nothing is in flight toward it. An instruction flagged as serialize-after turns the following instruction into such a barrier. A squash overrides everything. It takes two cycles, and the second of them signals the surrounding logic to flush its skid buffer and in-flight count.

Top module: `rename_stall_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the state is Idle (code 1) and allow_o, block_o, unblock_o and flush_o are all 0. State codes are Running=0, Idle=1, StartSquash=2, Squashing=3, Blocked=4, Unblocking=5 and SerializeStall=6.
- R2: Let demand = min(WIDTH, valid_count_i), and let each adjusted free count = max(free - inflight_i, 0). In Idle, Running or Unblocking, with no squash, no downstream stall and no barrier pending, allow_o = min(demand, adjusted ROB, adjusted IQ, adjusted LSQ).
- R3: A structure is full when its adjusted free count is below demand. full_src_o reports the first full one in the order ROB (0), IQ (1), LSQ (2), and reports NONE (3) when none is full.
- R4: In Idle, Running or Unblocking, a full structure or a stall request from either downstream stage moves the state to Blocked and pulses block_o for that cycle. A downstream stall forces allow_o to 0. In Blocked, allow_o is 0.
- R5: Blocked is left once no stall request and no full structure remains. The next state is Unblocking if skid_count_i is nonzero and otherwise Running (or Idle when no instruction is valid), and unblock_o pulses in that cycle.
- R6: Unblocking goes on to Running or Idle only in a cycle where skid_count_i is 0. While the skid buffer is non-empty, Unblocking renames allow_o instructions and stays put.
- R7: A barrier (barrier_i, or a pending serialize-after) with valid instructions, while the ROB is not empty or inflight_i is nonzero, gives allow_o = 0 and moves the state to SerializeStall. That state holds allow_o at 0 and returns to Running once rob_empty_i is 1 and inflight_i is 0. A drained barrier is renamed alone (allow_o = 1).
- R8: ser_after_i marks the next instruction to rename as a barrier. The mark is cleared when that barrier renames or on a squash.
- R9: squash_i overrides every other condition. The state goes to StartSquash, then Squashing, then Idle. allow_o is 0 in all of these and whenever squash_i is high, and flush_o is 1 exactly in Squashing.
- R10: With no other condition active, the state is Running when valid_count_i is nonzero and Idle when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| squash_i | input | 1 | Squash request for the thread |
| rob_free_i | input | CNT_W | Free reorder-buffer entries |
| iq_free_i | input | CNT_W | Free issue-queue entries |
| lsq_free_i | input | CNT_W | Free load/store-queue entries |
| inflight_i | input | CNT_W | Instructions sent but not yet counted by the back-end |
| exe_stall_i | input | 1 | Stall request from the execute stage |
| ret_stall_i | input | 1 | Stall request from the retire stage |
| rob_empty_i | input | 1 | Reorder buffer is empty |
| barrier_i | input | 1 | Oldest offered instruction is serializing |
| ser_after_i | input | 1 | An instruction renamed this cycle serializes its successor |
| skid_count_i | input | SKID_W | Skid-buffer occupancy |
| valid_count_i | input | AW | Valid instructions on offer |
| state_o | output | 3 | Current state code |
| allow_o | output | AW | Instructions allowed to rename this cycle |
| full_src_o | output | 2 | Full-stall source code |
| block_o | output | 1 | Pulse: tell the previous stage to block |
| unblock_o | output | 1 | Pulse: tell the previous stage to unblock |
| flush_o | output | 1 | Clear skid buffer and in-flight count |

## Verification
The capacity path is swept over every combination of three free counts from 0 to 7, in-flight counts from 0 to 3 and valid counts from 0 to 4. Each point starts from a fresh Idle state. The sweep separates clipping by width, by offered count and by each structure. It also shows whether subtracting the in-flight count saturates at zero, and whether the ROB-over-IQ-over-LSQ priority holds when several structures are short at once. Directed sequences then cover the rest of the state machine. They block on each downstream stall, release with and without a skid backlog, hold and release a barrier against a ROB flag and an in-flight count that fall separately, and carry a serialize-after mark across a cycle. They also squash from Running and from Blocked, showing that a squash beats a stall and wipes the pending mark.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SQ_START = 3'd2,
    ST_SQ_DRAIN = 3'd3,
    ST_BLOCK    = 3'd4,
    ST_UNBLOCK  = 3'd5,
    ST_SER      = 3'd6
  } rsc_state_e;

  typedef enum logic [1:0] {
    SRC_ROB  = 2'd0,
    SRC_IQ   = 2'd1,
    SRC_LSQ  = 2'd2,
    SRC_NONE = 2'd3
  } rsc_src_e;

  localparam int NUM_RES = 3;

endpackage

// File: rtl/rsc_capacity.sv
module rsc_capacity
  import rsc_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int CNT_W = 6,
  parameter int AW    = 3
) (
  input  logic [NUM_RES-1:0][CNT_W-1:0] free_i,
  input  logic [CNT_W-1:0]              inflight_i,
  input  logic [AW-1:0]                 valid_i,
  output logic [AW-1:0]                 cap_o,
  output logic                          any_full_o,
  output rsc_src_e                      src_o
);

  localparam int MW = (CNT_W > AW) ? CNT_W : AW;

  logic [MW-1:0]              demand;
  logic [NUM_RES-1:0][MW-1:0] adj;
  logic [NUM_RES-1:0]         full;
  logic [MW-1:0]              lim;

  // Offered group, clipped to the stage width.
  always_comb begin
    if (MW'(valid_i) > MW'(WIDTH)) demand = MW'(WIDTH);
    else                           demand = MW'(valid_i);
  end

  // Free space per structure after discounting in-flight work, saturating.
  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    assign adj[g]  = (free_i[g] > inflight_i) ? MW'(free_i[g] - inflight_i) : '0;
    assign full[g] = (adj[g] < demand);
  end

  always_comb begin
    lim = demand;
    for (int k = 0; k < NUM_RES; k++) begin
      if (adj[k] < lim) lim = adj[k];
    end
  end

  assign cap_o      = lim[AW-1:0];
  assign any_full_o = |full;

  // Fixed reporting order: ROB, then IQ, then LSQ.
  always_comb begin
    if (full[0])      src_o = SRC_ROB;
    else if (full[1]) src_o = SRC_IQ;
    else if (full[2]) src_o = SRC_LSQ;
    else              src_o = SRC_NONE;
  end

endmodule

// File: rtl/rsc_serial.sv
module rsc_serial (
  input  logic clk,
  input  logic rst_n,
  input  logic squash_i,
  input  logic ser_after_i,
  input  logic consume_i,
  input  logic barrier_i,
  output logic barrier_eff_o
);

  logic pend_q;
  logic pend_nx;
  logic pend_en;

  always_comb begin
    pend_nx = pend_q;
    if (squash_i) begin
      pend_nx = 1'b0;
    end else begin
      if (consume_i)   pend_nx = 1'b0;
      if (ser_after_i) pend_nx = 1'b1;
    end
  end

  assign pend_en = (pend_nx != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_nx;
  end

  assign barrier_eff_o = barrier_i | pend_q;

  // A squash always leaves no pending serialize mark behind.
  p_squash_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> !pend_q);

endmodule

// File: rtl/rsc_fsm.sv
module rsc_fsm
  import rsc_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          squash_i,
  input  logic          dn_stall_i,
  input  logic          any_full_i,
  input  logic          barrier_i,
  input  logic          drained_i,
  input  logic          valid_nz_i,
  input  logic          skid_nz_i,
  input  logic [AW-1:0] cap_i,
  output rsc_state_e    state_o,
  output logic [AW-1:0] allow_o,
  output logic          block_o,
  output logic          unblock_o,
  output logic          flush_o,
  output logic          consume_o
);

  rsc_state_e state_q;
  rsc_state_e state_nx;
  logic       state_en;
  logic       run_st;
  logic       stall;
  logic       hold;

  assign run_st = (state_q == ST_RUN) || (state_q == ST_IDLE) || (state_q == ST_UNBLOCK);
  assign stall  = dn_stall_i | any_full_i;
  assign hold   = barrier_i & valid_nz_i & ~drained_i;

  // Next-state decision, squash first, then blocking, then serializing.
  always_comb begin
    state_nx = state_q;
    if (squash_i) begin
      state_nx = ST_SQ_START;
    end else begin
      unique case (state_q)
        ST_SQ_START: state_nx = ST_SQ_DRAIN;
        ST_SQ_DRAIN: state_nx = ST_IDLE;
        ST_BLOCK: begin
          if (stall)           state_nx = ST_BLOCK;
          else if (skid_nz_i)  state_nx = ST_UNBLOCK;
          else if (valid_nz_i) state_nx = ST_RUN;
          else                 state_nx = ST_IDLE;
        end
        ST_SER: begin
          if (drained_i) state_nx = ST_RUN;
        end
        ST_RUN, ST_IDLE, ST_UNBLOCK: begin
          if (stall)                                  state_nx = ST_BLOCK;
          else if (hold)                              state_nx = ST_SER;
          else if ((state_q == ST_UNBLOCK) && skid_nz_i) state_nx = ST_UNBLOCK;
          else if (valid_nz_i)                        state_nx = ST_RUN;
          else                                        state_nx = ST_IDLE;
        end
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  assign state_en = (state_nx != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (state_en) state_q <= state_nx;
  end

  // Rename grant for this cycle.
  always_comb begin
    allow_o = '0;
    if (run_st && !squash_i && !dn_stall_i && !hold) begin
      if (barrier_i && (cap_i != '0)) allow_o = AW'(1);
      else                            allow_o = cap_i;
    end
  end

  assign consume_o = barrier_i & (allow_o != '0);
  assign block_o   = (state_nx == ST_BLOCK) && (state_q != ST_BLOCK);
  assign unblock_o = (state_q == ST_BLOCK) &&
                     ((state_nx == ST_UNBLOCK) || (state_nx == ST_RUN) || (state_nx == ST_IDLE));
  assign flush_o   = (state_q == ST_SQ_DRAIN);
  assign state_o   = state_q;

  p_squash_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> (state_q == ST_SQ_START));

  p_drain_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SQ_DRAIN) |-> ($past(state_q) == ST_SQ_START));

  p_ser_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SER) |-> (allow_o == '0));

  p_ser_exit_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && ($past(state_q) == ST_SER)) |-> $past(drained_i));

  p_unblock_skid_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((state_q == ST_RUN) || (state_q == ST_IDLE)) && ($past(state_q) == ST_UNBLOCK))
      |-> !$past(skid_nz_i));

  p_blocked_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLOCK) |-> (allow_o == '0));

  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({block_o, unblock_o, flush_o}));

endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl
  import rsc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int CNT_W  = 6,
  parameter int SKID_W = 4,
  parameter int AW     = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              squash_i,
  input  logic [CNT_W-1:0]  rob_free_i,
  input  logic [CNT_W-1:0]  iq_free_i,
  input  logic [CNT_W-1:0]  lsq_free_i,
  input  logic [CNT_W-1:0]  inflight_i,
  input  logic              exe_stall_i,
  input  logic              ret_stall_i,
  input  logic              rob_empty_i,
  input  logic              barrier_i,
  input  logic              ser_after_i,
  input  logic [SKID_W-1:0] skid_count_i,
  input  logic [AW-1:0]     valid_count_i,
  output logic [2:0]        state_o,
  output logic [AW-1:0]     allow_o,
  output logic [1:0]        full_src_o,
  output logic              block_o,
  output logic              unblock_o,
  output logic              flush_o
);

  logic [NUM_RES-1:0][CNT_W-1:0] free_vec;
  logic [AW-1:0]                 cap;
  logic                          any_full;
  rsc_src_e                      src;
  rsc_state_e                    state;
  logic                          barrier_eff;
  logic                          consume;
  logic                          drained;

  assign free_vec = {lsq_free_i, iq_free_i, rob_free_i};
  assign drained  = rob_empty_i && (inflight_i == '0);

  rsc_capacity #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W),
    .AW    (AW)
  ) u_cap (
    .free_i     (free_vec),
    .inflight_i (inflight_i),
    .valid_i    (valid_count_i),
    .cap_o      (cap),
    .any_full_o (any_full),
    .src_o      (src)
  );

  rsc_serial u_ser (
    .clk           (clk),
    .rst_n         (rst_n),
    .squash_i      (squash_i),
    .ser_after_i   (ser_after_i),
    .consume_i     (consume),
    .barrier_i     (barrier_i),
    .barrier_eff_o (barrier_eff)
  );

  rsc_fsm #(
    .AW (AW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .squash_i   (squash_i),
    .dn_stall_i (exe_stall_i | ret_stall_i),
    .any_full_i (any_full),
    .barrier_i  (barrier_eff),
    .drained_i  (drained),
    .valid_nz_i (valid_count_i != '0),
    .skid_nz_i  (skid_count_i != '0),
    .cap_i      (cap),
    .state_o    (state),
    .allow_o    (allow_o),
    .block_o    (block_o),
    .unblock_o  (unblock_o),
    .flush_o    (flush_o),
    .consume_o  (consume)
  );

  assign state_o    = state;
  assign full_src_o = src;

  p_grant_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_o <= valid_count_i) && (allow_o <= AW'(WIDTH)));

  p_full_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_src_o != SRC_NONE) |-> (allow_o < valid_count_i));

endmodule

// File: tb/rename_stall_ctrl_test.sv
`timescale 1ns/1ps
module rename_stall_ctrl_test;

  localparam int WIDTH  = 4;
  localparam int CNT_W  = 6;
  localparam int SKID_W = 4;
  localparam int AW     = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              squash_i;
  logic [CNT_W-1:0]  rob_free_i, iq_free_i, lsq_free_i, inflight_i;
  logic              exe_stall_i, ret_stall_i, rob_empty_i, barrier_i, ser_after_i;
  logic [SKID_W-1:0] skid_count_i;
  logic [AW-1:0]     valid_count_i;
  logic [2:0]        state_o;
  logic [AW-1:0]     allow_o;
  logic [1:0]        full_src_o;
  logic              block_o, unblock_o, flush_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rename_stall_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W), .SKID_W(SKID_W)) uut (
    .clk(clk), .rst_n(rst_n), .squash_i(squash_i),
    .rob_free_i(rob_free_i), .iq_free_i(iq_free_i), .lsq_free_i(lsq_free_i),
    .inflight_i(inflight_i), .exe_stall_i(exe_stall_i), .ret_stall_i(ret_stall_i),
    .rob_empty_i(rob_empty_i), .barrier_i(barrier_i), .ser_after_i(ser_after_i),
    .skid_count_i(skid_count_i), .valid_count_i(valid_count_i),
    .state_o(state_o), .allow_o(allow_o), .full_src_o(full_src_o),
    .block_o(block_o), .unblock_o(unblock_o), .flush_o(flush_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    squash_i = 0; rob_free_i = 20; iq_free_i = 20; lsq_free_i = 20; inflight_i = 0;
    exe_stall_i = 0; ret_stall_i = 0; rob_empty_i = 1; barrier_i = 0; ser_after_i = 0;
    skid_count_i = 0; valid_count_i = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    #7;
    // R1: reset state
    chk("R1 state in reset", state_o, 1);
    chk("R1 allow in reset", allow_o, 0);
    chk("R1 pulses in reset", {block_o, unblock_o, flush_o}, 0);
    rst_n = 1;
    tick();
    chk("R1 state after reset", state_o, 1);

    // R2 R3 R4 R10: capacity sweep, each point from a fresh Idle state
    for (int r = 0; r < 8; r++)
      for (int q = 0; q < 8; q++)
        for (int l = 0; l < 8; l++)
          for (int f = 0; f < 4; f++)
            for (int v = 0; v < 5; v++) begin
              int dem, ar, aq, al, cp, src, nst;
              bit fr, fq, fl;
              rst_n = 0; #0.5; rst_n = 1;
              rob_free_i = r; iq_free_i = q; lsq_free_i = l; inflight_i = f;
              valid_count_i = v;
              #0.5;
              dem = (v < WIDTH) ? v : WIDTH;
              ar = (r > f) ? r - f : 0;
              aq = (q > f) ? q - f : 0;
              al = (l > f) ? l - f : 0;
              cp = dem;
              if (ar < cp) cp = ar;
              if (aq < cp) cp = aq;
              if (al < cp) cp = al;
              fr = ar < dem; fq = aq < dem; fl = al < dem;
              src = fr ? 0 : fq ? 1 : fl ? 2 : 3;
              nst = (fr | fq | fl) ? 4 : (v > 0) ? 0 : 1;
              chk("R2 allow", allow_o, cp);
              chk("R3 full source", full_src_o, src);
              chk("R4 block pulse", block_o, int'(fr | fq | fl));
              tick();
              chk("R10/R4 next state", state_o, nst);
            end

    // R4/R5/R6: execute-stage stall with skid backlog
    idle_inputs();
    rst_n = 0; #1; rst_n = 1;
    valid_count_i = 3; exe_stall_i = 1;
    #1;
    chk("R4 allow under stall", allow_o, 0);
    chk("R4 block pulse", block_o, 1);
    tick();
    chk("R4 state blocked", state_o, 4);
    chk("R4 block pulse once", block_o, 0);
    chk("R4 blocked allow", allow_o, 0);
    tick();
    chk("R4 stays blocked", state_o, 4);
    exe_stall_i = 0; skid_count_i = 2; valid_count_i = 2;
    #1;
    chk("R5 unblock pulse", unblock_o, 1);
    tick();
    chk("R5 to unblocking", state_o, 5);
    chk("R6 drain grant", allow_o, 2);
    tick();
    chk("R6 stays unblocking", state_o, 5);
    skid_count_i = 0;
    tick();
    chk("R6 to running", state_o, 0);

    // R4/R5: retire-stage stall without backlog
    ret_stall_i = 1;
    #1;
    chk("R4 retire stall block", block_o, 1);
    tick();
    chk("R4 retire stall state", state_o, 4);
    ret_stall_i = 0;
    #1;
    chk("R5 unblock without skid", unblock_o, 1);
    tick();
    chk("R5 straight to running", state_o, 0);

    // R10: no valid instructions goes idle
    valid_count_i = 0;
    tick();
    chk("R10 idle when empty", state_o, 1);
    valid_count_i = 2;
    tick();

    // R7: barrier hold and release
    barrier_i = 1; rob_empty_i = 0;
    #1;
    chk("R7 barrier hold allow", allow_o, 0);
    tick();
    chk("R7 serialize stall", state_o, 6);
    rob_empty_i = 1; inflight_i = 1;
    #1;
    chk("R7 stall allow", allow_o, 0);
    tick();
    chk("R7 waits for in-flight", state_o, 6);
    inflight_i = 0;
    tick();
    chk("R7 released", state_o, 0);
    chk("R7 barrier alone", allow_o, 1);
    tick();
    barrier_i = 0;

    // R8: serialize-after marks the next instruction
    ser_after_i = 1;
    #1;
    chk("R8 normal grant", allow_o, 2);
    tick();
    ser_after_i = 0; rob_empty_i = 0;
    #1;
    chk("R8 next held", allow_o, 0);
    tick();
    chk("R8 serialize stall", state_o, 6);
    rob_empty_i = 1;
    tick();
    chk("R8 released", state_o, 0);
    valid_count_i = 3;
    #1;
    chk("R8 marked renames alone", allow_o, 1);
    tick();
    chk("R8 mark cleared", allow_o, 3);

    // R9: squash from running
    squash_i = 1;
    #1;
    chk("R9 squash allow", allow_o, 0);
    tick();
    chk("R9 start squash", state_o, 2);
    squash_i = 0;
    chk("R9 no flush yet", flush_o, 0);
    chk("R9 start allow", allow_o, 0);
    tick();
    chk("R9 squashing", state_o, 3);
    chk("R9 flush", flush_o, 1);
    tick();
    chk("R9 back to idle", state_o, 1);

    // R9/R8: squash overrides a stall and wipes a pending mark
    valid_count_i = 2; exe_stall_i = 1; ser_after_i = 1;
    tick();
    chk("R9 blocked before squash", state_o, 4);
    ser_after_i = 0; squash_i = 1;
    tick();
    chk("R9 squash beats stall", state_o, 2);
    squash_i = 0; exe_stall_i = 0;
    tick(); tick();
    chk("R9 idle after squash", state_o, 1);
    rob_empty_i = 0;
    #1;
    chk("R8 mark wiped by squash", allow_o, 2);
    tick();
    chk("R8 no serialize stall", state_o, 0);

    finish_run();
  end

endmodule